// File: doc/BRIEF.md
# Ultimately Periodic Activation Word Generator

This block produces a one-bit activation stream that follows an ultimately periodic binary word. The word is a finite head emitted once, followed by a loop body that repeats without end. A 1 marks an instant in which a data value is present and a 0 marks an absent instant. Two such words, A and B, are configured at run time. Each has a head vector and a body vector, and each vector has its own programmable length.

The block advances one instant for every cycle in which `step` is high. A mode input selects which stream appears on the output: word A as written, the complement of A, or A sampling B. In the sampled form, B moves forward only on the instants where A is 1. A running counter totals the ones that the selected output has produced.

The block is meant to drive the enable of a consumer on a derived schedule, or to act as a reference source for schedules written as `head(body)` words.

Top module: `upw_clock_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both words return to instant 0 and `ones_cnt` clears to 0. After reset, in mode 0, `clk_bit` equals the first bit of word A.
- R2: For a word with head vector H of length P and body vector V of length L (1 ≤ L ≤ MAXLEN, 0 ≤ P ≤ MAXLEN), the bit at instant k is H[k] when k < P, and V[(k−P) mod L] otherwise. Bit 0 of each vector is emitted first. A head length of 0 starts the word directly in the body.
- R3: In a cycle where `step` is low, neither word advances and `ones_cnt` keeps its value.
- R4: The `mode` encoding is: 0 gives word A; 1 gives the complement of A; 2 gives A sampling B; 3 behaves the same as 0.
- R5: In mode 1, `clk_bit` is the complement of A's current bit. After i stepped instants from reset in mode 1, `ones_cnt` equals i minus the number of ones in the first i bits of A.
- R6: In mode 2, the following holds on each stepped instant. If A's current bit is 0, the output is 0 and B does not advance. If A's current bit is 1, the output is B's current bit and B advances one position. B follows this advance rule in every mode.
- R7: After i stepped instants from reset in mode 2, `ones_cnt` equals the number of ones in the first n bits of B, where n is the number of ones in the first i bits of A.
- R8: On each stepped instant, `ones_cnt` increases by the value of `clk_bit` during that cycle, modulo 2^CNTW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance one instant |
| mode | input | 2 | Output select (0 A, 1 not A, 2 A on B, 3 A) |
| a_head | input | MAXLEN | Head bits of word A, bit 0 first |
| a_head_len | input | clog2(MAXLEN+1) | Head length of A |
| a_body | input | MAXLEN | Repeating body of word A |
| a_body_len | input | clog2(MAXLEN+1) | Body length of A (at least 1) |
| b_head | input | MAXLEN | Head bits of word B |
| b_head_len | input | clog2(MAXLEN+1) | Head length of B |
| b_body | input | MAXLEN | Repeating body of word B |
| b_body_len | input | clog2(MAXLEN+1) | Body length of B (at least 1) |
| clk_bit | output | 1 | Current bit of the selected stream |
| ones_cnt | output | CNTW | Ones emitted by the selected stream so far |

## Verification
The first configuration is a word A with a three-bit head of ones and a ten-bit irregular body, paired with a word B that has a one-bit zero head and a six-bit body. Each mode runs from reset with `step` held high, which checks the complement and sampling count identities against counts computed independently. A run with a random `step` and random mode changes shows that idle cycles hold all state and that B stalls on A's zeros even when the output is not in sampled mode. A second configuration uses an empty head on A and a one-bit body on B, which exercises the direct start in the body and the shortest possible wrap.

// File: rtl/upw_pkg.sv
package upw_pkg;

    typedef enum logic [1:0] {
        SEL_WORD    = 2'd0,
        SEL_INVERT  = 2'd1,
        SEL_SAMPLED = 2'd2,
        SEL_ALIAS   = 2'd3
    } sel_t;

    typedef struct packed {
        logic a_bit;
        logic b_bit;
    } word_bits_t;

    function automatic logic pick_output(input sel_t sel, input word_bits_t wb);
        case (sel)
            SEL_INVERT:  return ~wb.a_bit;
            SEL_SAMPLED: return wb.a_bit & wb.b_bit;
            default:     return wb.a_bit;
        endcase
    endfunction

endpackage

// File: rtl/upw_word_gen.sv
module upw_word_gen #(
    parameter int MAXLEN = 32,
    localparam int LW = $clog2(MAXLEN + 1),
    localparam int IW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
    localparam int PW = LW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [MAXLEN-1:0] head,
    input  logic [LW-1:0]     head_len,
    input  logic [MAXLEN-1:0] body,
    input  logic [LW-1:0]     body_len,
    output logic              cur_bit,
    output logic [PW-1:0]     pos
);

    logic [PW-1:0] total;
    logic [PW-1:0] hl_ext;
    logic [PW-1:0] off;
    logic [PW-1:0] nxt;
    logic          in_head;

    assign hl_ext  = {1'b0, head_len};
    assign total   = hl_ext + {1'b0, body_len};
    assign in_head = pos < hl_ext;
    assign off     = pos - hl_ext;
    assign nxt     = pos + 1'b1;

    always_comb begin
        if (in_head) cur_bit = head[IW'(pos)];
        else         cur_bit = body[IW'(off)];
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (adv)
            pos <= (nxt >= total) ? hl_ext : nxt;
    end

    // R1: reset puts the word at instant 0
    a_r1_reset_pos: assert property (@(posedge clk) rst |=> pos == '0);

    // R3: no advance without a step
    a_r3_hold_pos: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

    // R2: leaving the last body position lands on the first body position
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && (nxt >= total)) |=> pos == $past(hl_ext));

endmodule

// File: rtl/upw_ones_count.sv
module upw_ones_count #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            bit_in,
    output logic [CNTW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en && bit_in)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/upw_clock_gen.sv
module upw_clock_gen #(
    parameter int MAXLEN = 32,
    parameter int CNTW   = 16,
    localparam int LW = $clog2(MAXLEN + 1),
    localparam int PW = LW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [1:0]        mode,
    input  logic [MAXLEN-1:0] a_head,
    input  logic [LW-1:0]     a_head_len,
    input  logic [MAXLEN-1:0] a_body,
    input  logic [LW-1:0]     a_body_len,
    input  logic [MAXLEN-1:0] b_head,
    input  logic [LW-1:0]     b_head_len,
    input  logic [MAXLEN-1:0] b_body,
    input  logic [LW-1:0]     b_body_len,
    output logic              clk_bit,
    output logic [CNTW-1:0]   ones_cnt
);
    import upw_pkg::*;

    word_bits_t    wb;
    logic [PW-1:0] a_pos;
    logic [PW-1:0] b_pos;
    logic          b_adv;
    sel_t          sel;

    assign sel   = sel_t'(mode);
    assign b_adv = step & wb.a_bit;

    upw_word_gen #(.MAXLEN(MAXLEN)) u_word_a (
        .clk(clk), .rst(rst), .adv(step),
        .head(a_head), .head_len(a_head_len),
        .body(a_body), .body_len(a_body_len),
        .cur_bit(wb.a_bit), .pos(a_pos)
    );

    upw_word_gen #(.MAXLEN(MAXLEN)) u_word_b (
        .clk(clk), .rst(rst), .adv(b_adv),
        .head(b_head), .head_len(b_head_len),
        .body(b_body), .body_len(b_body_len),
        .cur_bit(wb.b_bit), .pos(b_pos)
    );

    assign clk_bit = pick_output(sel, wb);

    upw_ones_count #(.CNTW(CNTW)) u_count (
        .clk(clk), .rst(rst), .en(step),
        .bit_in(clk_bit), .cnt(ones_cnt)
    );

    // R1: counter cleared by reset
    a_r1_reset_cnt: assert property (@(posedge clk) rst |=> ones_cnt == '0);

    // R8: each stepped instant adds the output bit
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        step |=> ones_cnt == CNTW'($past(ones_cnt) + CNTW'($past(clk_bit))));

    // R3: idle cycles hold the count and both positions
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(ones_cnt) && $stable(a_pos) && $stable(b_pos)));

    // R6: B stalls on a zero of A
    a_r6_b_stall: assert property (@(posedge clk) disable iff (rst)
        (step && !wb.a_bit) |=> $stable(b_pos));

    // R6: sampled output is zero whenever A is zero
    a_r6_sampled_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SAMPLED && !wb.a_bit) |-> !clk_bit);

    // R5: inverted output never equals A
    a_r5_invert: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_INVERT) |-> (clk_bit != wb.a_bit));

endmodule

// File: tb/sim_upw_clock_gen.sv
module sim_upw_clock_gen;
    localparam int MAXLEN = 32;
    localparam int CNTW   = 16;
    localparam int LW     = $clog2(MAXLEN + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [MAXLEN-1:0] a_head = '0, a_body = '0, b_head = '0, b_body = '0;
    logic [LW-1:0] a_head_len = '0, a_body_len = LW'(1), b_head_len = '0, b_body_len = LW'(1);
    logic clk_bit;
    logic [CNTW-1:0] ones_cnt;

    int checks = 0;
    int errors = 0;
    int ka = 0, kb = 0, cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    upw_clock_gen #(.MAXLEN(MAXLEN), .CNTW(CNTW)) u0 (
        .clk(clk), .rst(rst), .step(step), .mode(mode),
        .a_head(a_head), .a_head_len(a_head_len), .a_body(a_body), .a_body_len(a_body_len),
        .b_head(b_head), .b_head_len(b_head_len), .b_body(b_body), .b_body_len(b_body_len),
        .clk_bit(clk_bit), .ones_cnt(ones_cnt)
    );

    function automatic logic [MAXLEN-1:0] seq(input logic [MAXLEN-1:0] v, input int n);
        logic [MAXLEN-1:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = v[n-1-i];
        return r;
    endfunction

    function automatic int wbit(input logic [MAXLEN-1:0] h, input int hl,
                                input logic [MAXLEN-1:0] b, input int bl, input int k);
        if (k < hl) return int'(h[k]);
        return int'(b[(k - hl) % bl]);
    endfunction

    function automatic int a_at(input int k);
        return wbit(a_head, int'(a_head_len), a_body, int'(a_body_len), k);
    endfunction

    function automatic int b_at(input int k);
        return wbit(b_head, int'(b_head_len), b_body, int'(b_body_len), k);
    endfunction

    function automatic int ones_a(input int n);
        int s = 0;
        for (int k = 0; k < n; k++) s += a_at(k);
        return s;
    endfunction

    function automatic int ones_b(input int n);
        int s = 0;
        for (int k = 0; k < n; k++) s += b_at(k);
        return s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ka = 0; kb = 0; cnt = 0;
        #1;
        check("R1 count after reset", int'(ones_cnt), 0);
    endtask

    task automatic do_step(input bit en_v, input int mode_v);
        int ea, eb, eo;
        string tag;
        @(negedge clk);
        step = en_v; mode = 2'(mode_v);
        #1;
        ea = a_at(ka); eb = b_at(kb);
        case (mode_v)
            1: begin eo = 1 - ea; tag = "R5 inverted bit"; end
            2: begin eo = ea & eb; tag = "R6 sampled bit"; end
            3: begin eo = ea; tag = "R4 alias mode bit"; end
            default: begin eo = ea; tag = "R2 word bit"; end
        endcase
        check(tag, int'(clk_bit), eo);
        check("R8 ones count", int'(ones_cnt), cnt);
        if (en_v) begin
            cnt = (cnt + eo) % (1 << CNTW);
            if (ea == 1) kb++;
            ka++;
        end
    endtask

    task automatic run_const(input int mode_v, input int n);
        do_reset();
        if (mode_v == 0) check("R1 first bit of A", int'(clk_bit), a_at(0));
        for (int i = 0; i < n; i++) do_step(1'b1, mode_v);
        do_step(1'b0, mode_v);
        if (mode_v == 1) check("R5 count identity", int'(ones_cnt), n - ones_a(n));
        if (mode_v == 2) check("R7 count identity", int'(ones_cnt), ones_b(ones_a(n)));
    endtask

    task automatic run_mixed(input int n);
        int held;
        do_reset();
        for (int i = 0; i < n; i++) begin
            do_step(($urandom % 3) != 0, int'($urandom % 4));
            if (!step) begin
                held = int'(ones_cnt);
                do_step(1'b0, int'(mode));
                check("R3 idle keeps count", int'(ones_cnt), held);
            end
        end
    endtask

    initial begin
        a_head = seq(MAXLEN'(3'b111), 3);          a_head_len = LW'(3);
        a_body = seq(MAXLEN'(10'b0101100101), 10); a_body_len = LW'(10);
        b_head = seq(MAXLEN'(1'b0), 1);            b_head_len = LW'(1);
        b_body = seq(MAXLEN'(6'b000111), 6);       b_body_len = LW'(6);
        for (int m = 0; m < 4; m++) run_const(m, 40);
        run_mixed(300);

        a_head = '0;                               a_head_len = LW'(0);
        a_body = seq(MAXLEN'(3'b110), 3);          a_body_len = LW'(3);
        b_head = seq(MAXLEN'(4'b1011), 4);         b_head_len = LW'(4);
        b_body = MAXLEN'(1);                       b_body_len = LW'(1);
        for (int m = 0; m < 3; m++) run_const(m, 25);
        run_mixed(200);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule